// File: doc/BRIEF.md
# Layer Fetch Address Generator

This block produces the stream of memory read addresses for one display layer, in step with the raster timing. The timing generator pulses `line_start` once per displayed line. For each accepted line, the block emits one 32-bit word address per pair of 16-bit pixels across the window width. The addresses leave on a valid/ready stream toward the memory requester. `frame_end` pulses once the final word of the final line has been taken.

A packed 32-bit mode word configures the layer:

| Bits  | Meaning |
|-------|---------|
| 15:0  | Number of lines minus one |
| 30:16 | Line stride, in 64-byte units |
| 31    | Layer enable |

A separate two-bit output enable must also read all ones for the layer to run. Two frame buffer base addresses allow double buffering. A select input picks between them, but the choice only takes effect at a frame boundary. A window origin (x, y in pixels) offsets the first fetched address within the buffer.

Stream rules: `rd_addr` is meaningful only while `rd_valid` is high. A word is taken on a clock edge where `rd_valid` and `rd_ready` are both high. While `rd_valid` is high and `rd_ready` is low, `rd_valid` and `rd_addr` hold their values. The one exception is when the layer is disabled, which withdraws the request. Back-pressure does not stall the timing side. A `line_start` that arrives while a line is still being fetched is dropped.

Top module: `layer_fetch_agen`

## Requirements
- R1: Addresses are issued (`rd_valid` high) only while mode bit 31 is 1 and `out_en` equals 2'b11. Otherwise `line_start` causes no request.
- R2: A `line_start` pulse while the layer is enabled and no line is in progress starts a line. `rd_valid` rises on the following cycle. A `line_start` during a line in progress has no effect on the addresses or the line count.
- R3: Each line issues ceil(`win_width`/2) word addresses, each 4 bytes above the previous one. A width of 0 issues none.
- R4: The first line of a frame starts at the selected base with bits 1:0 cleared, plus `win_y` × stride × 64, plus floor(`win_x`/2) × 4.
- R5: Each further line of the frame starts at the previous line's start plus (mode bits 30:16) × 64.
- R6: A frame holds (mode bits 15:0) + 1 lines. After the last line, the next `line_start` begins a new frame at the R4 address.
- R7: `frame_end` is high for exactly one cycle: the cycle after the last word of the last line is taken. It is never high at any other time.
- R8: While `rd_valid` is high and `rd_ready` is low, `rd_valid` and `rd_addr` are unchanged on the next cycle, unless the layer is disabled.
- R9: The buffer in use is buffer 0 after reset. It changes only at a frame end, to the value of `buf_sel` (0 = `buf0_base`, 1 = `buf1_base`) in the cycle the last word is taken.
- R10: Every issued address has bits 1:0 equal to zero.
- R11: Disabling the layer abandons any line in progress. The next frame restarts from its first line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | Line strobe from the raster timing |
| mode_word | input | 32 | Packed line count, stride and enable |
| out_en | input | 2 | Output enable pair, both bits needed |
| buf_sel | input | 1 | Requested frame buffer for the next frame |
| buf0_base | input | ADDR_W | Base byte address of buffer 0 |
| buf1_base | input | ADDR_W | Base byte address of buffer 1 |
| win_width | input | DIM_W | Window width in pixels |
| win_x | input | DIM_W | Window origin column in pixels |
| win_y | input | DIM_W | Window origin row in lines |
| rd_ready | input | 1 | Consumer accepts the current address |
| rd_valid | output | 1 | An address is offered |
| rd_addr | output | ADDR_W | Word-aligned read byte address |
| frame_end | output | 1 | One-cycle pulse after the last word of a frame |

## Verification
Some properties are checked on every cycle by the assertions:
- held requests under back-pressure;
- word alignment;
- `frame_end` following a final handshake and lasting one cycle;
- `rd_valid` starting only after a line strobe.

The actual address values, word counts per line and lines per frame are only shown by the bench. It sweeps small widths, line counts, strides and origins and compares each taken address with the arithmetic formula. Dropped mid-line strobes, mid-frame buffer selection, disabling mid-frame and zero width are likewise only visible in dedicated scenarios.

// File: rtl/agen_pkg.sv
package agen_pkg;
  localparam int MODE_W       = 32;
  localparam int LINES_LSB    = 0;
  localparam int LINES_W      = 16;
  localparam int STRIDE_LSB   = 16;
  localparam int STRIDE_W     = 15;
  localparam int ENABLE_BIT   = 31;
  localparam int STRIDE_SHIFT = 6;   // stride unit is 64 bytes
  localparam int WORD_SHIFT   = 2;   // one 32-bit word holds two pixels

  typedef struct packed {
    logic                layer_on;
    logic [STRIDE_W-1:0] stride_units;
    logic [LINES_W-1:0]  last_line;
  } mode_t;
endpackage

// File: rtl/agen_cfg.sv
module agen_cfg
  import agen_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DIM_W  = 16
) (
  input  logic [MODE_W-1:0]  mode_word,
  input  logic [1:0]         out_en,
  input  logic [DIM_W-1:0]   win_width,
  input  logic [DIM_W-1:0]   win_x,
  input  logic [DIM_W-1:0]   win_y,
  output logic               en,
  output logic [LINES_W-1:0] last_line,
  output logic [ADDR_W-1:0]  stride_bytes,
  output logic [DIM_W-1:0]   words,
  output logic [ADDR_W-1:0]  origin_off
);
  mode_t           m;
  logic [DIM_W:0]  width_plus;

  assign m            = mode_t'(mode_word);
  assign en           = m.layer_on && (out_en == 2'b11);
  assign last_line    = m.last_line;
  assign stride_bytes = ADDR_W'(m.stride_units) << STRIDE_SHIFT;
  assign width_plus   = {1'b0, win_width} + {{DIM_W{1'b0}}, 1'b1};
  assign words        = width_plus[DIM_W:1];
  assign origin_off   = (ADDR_W'(win_y) * stride_bytes)
                      + (ADDR_W'(win_x[DIM_W-1:1]) << WORD_SHIFT);
endmodule

// File: rtl/agen_line.sv
module agen_line
  import agen_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               accept,
  input  logic               word_done,
  input  logic               buf_sel,
  input  logic [ADDR_W-1:0]  buf0_base,
  input  logic [ADDR_W-1:0]  buf1_base,
  input  logic [LINES_W-1:0] last_line,
  input  logic [ADDR_W-1:0]  stride_bytes,
  input  logic [ADDR_W-1:0]  origin_off,
  output logic [ADDR_W-1:0]  line_addr,
  output logic               frame_end
);
  logic [LINES_W-1:0] line_idx;
  logic               act_sel;
  logic [ADDR_W-1:0]  base_raw;
  logic [ADDR_W-1:0]  first_addr;

  assign base_raw   = act_sel ? buf1_base : buf0_base;
  assign first_addr = {base_raw[ADDR_W-1:WORD_SHIFT], {WORD_SHIFT{1'b0}}} + origin_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_idx  <= '0;
      line_addr <= '0;
      frame_end <= 1'b0;
      act_sel   <= 1'b0;
    end else begin
      frame_end <= 1'b0;
      if (!en) begin
        line_idx <= '0;
      end else begin
        if (accept)
          line_addr <= (line_idx == '0) ? first_addr : line_addr + stride_bytes;
        if (word_done) begin
          if (line_idx == last_line) begin
            line_idx  <= '0;
            frame_end <= 1'b1;
            act_sel   <= buf_sel;
          end else begin
            line_idx <= line_idx + 1'b1;
          end
        end
      end
    end
  end

  p_fend_after_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> $past(word_done));
  p_fend_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !frame_end);
endmodule

// File: rtl/agen_word.sv
module agen_word
  import agen_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DIM_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              accept,
  input  logic [DIM_W-1:0]  words,
  input  logic [ADDR_W-1:0] line_addr,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              busy,
  output logic              word_done
);
  logic [DIM_W-1:0] idx;
  logic             last_word;

  assign last_word = (idx == words - DIM_W'(1));
  assign rd_valid  = busy && en;
  assign rd_addr   = line_addr + (ADDR_W'(idx) << WORD_SHIFT);
  assign word_done = rd_valid && rd_ready && last_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (!en) begin
      busy <= 1'b0;
    end else if (accept) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (busy && rd_ready) begin
      if (last_word) busy <= 1'b0;
      else           idx  <= idx + 1'b1;
    end
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> ((rd_valid && $stable(rd_addr)) || !en));
  p_align_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_addr[1:0] == 2'b00));
endmodule

// File: rtl/layer_fetch_agen.sv
module layer_fetch_agen
  import agen_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DIM_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic [31:0]       mode_word,
  input  logic [1:0]        out_en,
  input  logic              buf_sel,
  input  logic [ADDR_W-1:0] buf0_base,
  input  logic [ADDR_W-1:0] buf1_base,
  input  logic [DIM_W-1:0]  win_width,
  input  logic [DIM_W-1:0]  win_x,
  input  logic [DIM_W-1:0]  win_y,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              frame_end
);
  logic               en;
  logic [LINES_W-1:0] last_line;
  logic [ADDR_W-1:0]  stride_bytes;
  logic [DIM_W-1:0]   words;
  logic [ADDR_W-1:0]  origin_off;
  logic [ADDR_W-1:0]  line_addr;
  logic               busy;
  logic               word_done;
  logic               accept;

  assign accept = line_start && !busy && en && (words != '0);

  agen_cfg #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_cfg (
    .mode_word(mode_word), .out_en(out_en), .win_width(win_width),
    .win_x(win_x), .win_y(win_y), .en(en), .last_line(last_line),
    .stride_bytes(stride_bytes), .words(words), .origin_off(origin_off));

  agen_line #(.ADDR_W(ADDR_W)) u_line (
    .clk(clk), .rst_n(rst_n), .en(en), .accept(accept), .word_done(word_done),
    .buf_sel(buf_sel), .buf0_base(buf0_base), .buf1_base(buf1_base),
    .last_line(last_line), .stride_bytes(stride_bytes), .origin_off(origin_off),
    .line_addr(line_addr), .frame_end(frame_end));

  agen_word #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_word (
    .clk(clk), .rst_n(rst_n), .en(en), .accept(accept), .words(words),
    .line_addr(line_addr), .rd_ready(rd_ready), .rd_valid(rd_valid),
    .rd_addr(rd_addr), .busy(busy), .word_done(word_done));

  p_start_after_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> $past(line_start));
endmodule

// File: tb/test_layer_fetch_agen.sv
module test_layer_fetch_agen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_start = 1'b0;
  logic [31:0] mode_word = '0;
  logic [1:0]  out_en = 2'b11;
  logic        buf_sel = 1'b0;
  logic [31:0] buf0_base = 32'h1000_0000;
  logic [31:0] buf1_base = 32'h2000_0003;
  logic [15:0] win_width = '0;
  logic [15:0] win_x = '0;
  logic [15:0] win_y = '0;
  logic        rd_ready = 1'b0;
  logic        rd_valid;
  logic [31:0] rd_addr;
  logic        frame_end;

  int errors = 0;
  int checks = 0;
  logic        exp_sel = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  int c_w, c_lines, c_stride, c_x, c_y;

  always #4 clk = ~clk;

  layer_fetch_agen i_layer_fetch_agen (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .mode_word(mode_word),
    .out_en(out_en), .buf_sel(buf_sel), .buf0_base(buf0_base), .buf1_base(buf1_base),
    .win_width(win_width), .win_x(win_x), .win_y(win_y), .rd_ready(rd_ready),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .frame_end(frame_end));

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input int w, input int lines_m1, input int stride, input int x, input int y, input logic on);
    c_w = w; c_lines = lines_m1; c_stride = stride; c_x = x; c_y = y;
    win_width = 16'(w); win_x = 16'(x); win_y = 16'(y);
    mode_word = {on, 15'(stride), 16'(lines_m1)};
  endtask

  function automatic logic [31:0] exp_addr(input int line, input int word);
    logic [31:0] b;
    b = exp_sel ? buf1_base : buf0_base;
    b[1:0] = 2'b00;
    return b + 32'((c_y + line) * c_stride * 64) + 32'((c_x / 2) * 4) + 32'(word * 4);
  endfunction

  // ready: 0 = always, 1 = pseudo-random; stall_start pulses line_start during a stall
  task automatic do_line(input int line, input logic is_last, input int rmode, input logic stall_start);
    int w = 0;
    int guard = 0;
    int words = (c_w + 1) / 2;
    logic injected = 1'b0;
    @(negedge clk); line_start = 1'b1;
    @(negedge clk); line_start = 1'b0;
    chk(rd_valid == 1'b1, "R2 valid after strobe", 32'(rd_valid), 32'd1);
    while (w < words && guard < 1000) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rd_ready = (rmode == 0) ? 1'b1 : lfsr[0];
      if (stall_start && !injected) begin
        rd_ready = 1'b0; line_start = 1'b1; injected = 1'b1;
      end
      #1;
      if (rd_valid && rd_ready) begin
        chk(rd_addr == exp_addr(line, w), "R3/R4/R5 address", rd_addr, exp_addr(line, w));
        chk(rd_addr[1:0] == 2'b00, "R10 alignment", 32'(rd_addr[1:0]), 32'd0);
        w++;
      end else if (!rd_valid) begin
        chk(1'b0, "R3 valid dropped early", 32'(w), 32'(words));
        guard = 1000;
      end
      @(negedge clk); line_start = 1'b0; guard++;
    end
    rd_ready = 1'b0;
    if (is_last) exp_sel = buf_sel;
    chk(frame_end == is_last, "R7 frame_end timing", 32'(frame_end), 32'(is_last));
    chk(rd_valid == 1'b0, "R3 word count per line", 32'(rd_valid), 32'd0);
    @(negedge clk);
    chk(frame_end == 1'b0, "R7 one-cycle pulse", 32'(frame_end), 32'd0);
  endtask

  task automatic do_frame(input int rmode);
    for (int l = 0; l <= c_lines; l++) do_line(l, l == c_lines, rmode, 1'b0);
  endtask

  task automatic expect_quiet(input string req);
    @(negedge clk); line_start = 1'b1; rd_ready = 1'b1;
    @(negedge clk); line_start = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk(rd_valid == 1'b0, req, 32'(rd_valid), 32'd0);
      @(negedge clk);
    end
    rd_ready = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rd_valid == 1'b0, "reset valid", 32'(rd_valid), 32'd0);
    chk(frame_end == 1'b0, "reset frame_end", 32'(frame_end), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: layer bit off, then one output enable bit off
    set_cfg(4, 1, 1, 0, 0, 1'b0);
    expect_quiet("R1 layer bit clear");
    set_cfg(4, 1, 1, 0, 0, 1'b1); out_en = 2'b01;
    expect_quiet("R1 out_en partial");
    out_en = 2'b11;

    // R3: zero width issues nothing
    set_cfg(0, 0, 1, 0, 0, 1'b1);
    expect_quiet("R3 zero width");

    // Sweep (R3 R4 R5 R6 R7 R8 R9 R10), buffer select toggled per frame
    for (int w = 1; w <= 5; w++)
      for (int h = 0; h <= 2; h++)
        for (int s = 1; s <= 3; s++)
          for (int o = 0; o < 4; o++) begin
            set_cfg(w, h, s, (o & 1) * 3, (o >> 1) * 2, 1'b1);
            buf_sel = lfsr[3];
            do_frame((w + o) & 1);
          end

    // R6: a second frame on the same setup restarts at the first line
    set_cfg(3, 2, 2, 2, 1, 1'b1);
    do_frame(0);
    do_frame(1);

    // R9: change select mid-frame; current frame keeps the old buffer
    buf_sel = 1'b0;
    do_frame(0);
    do_line(0, 1'b0, 0, 1'b0);
    buf_sel = 1'b1;
    chk(exp_sel == 1'b0, "R9 model select", 32'(exp_sel), 32'd0);
    do_line(1, 1'b0, 0, 1'b0);
    do_line(2, 1'b1, 0, 1'b0);
    chk(exp_sel == 1'b1, "R9 select taken at frame end", 32'(exp_sel), 32'd1);
    do_frame(1);

    // R2: strobe during a stalled line is ignored
    set_cfg(6, 1, 1, 0, 0, 1'b1);
    do_line(0, 1'b0, 1, 1'b1);
    do_line(1, 1'b1, 1, 1'b1);

    // R11: disable mid-frame, frame restarts at its first line
    set_cfg(4, 2, 3, 0, 1, 1'b1);
    do_line(0, 1'b0, 0, 1'b0);
    @(negedge clk); line_start = 1'b1; rd_ready = 1'b0;
    @(negedge clk); line_start = 1'b0; mode_word[31] = 1'b0;
    #1 chk(rd_valid == 1'b0, "R11 disable drops request", 32'(rd_valid), 32'd0);
    @(negedge clk); mode_word[31] = 1'b1;
    @(negedge clk);
    chk(rd_valid == 1'b0, "R11 no resume without strobe", 32'(rd_valid), 32'd0);
    do_frame(0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule